// File: doc/BRIEF.md
# ADC Power-Mode Conversion Sequencer

This block sits on the host side of a sampling analog-to-digital converter. It issues the active-low convert-start strobe and watches the converter's busy flag, so that the converter can be used in its power-saving modes. A 2-bit power-management setting selects the mode. In normal operation the strobe is a short low pulse. In the sleep-after-conversion modes the strobe is held low long enough for the converter to wake, because the falling edge wakes the converter and the rising edge starts the conversion. When the busy flag falls, the block emits a one-cycle completion pulse. It also tracks whether the converter has gone back to sleep.

After reset the converter needs one of two start-up paths. If the host has not issued a configuration write, the first sample request produces a calibration strobe, and the block then holds off for the whole power-on calibration time. If a configuration write came before any strobe, calibration is skipped. Conversions are then held off only until the supply settling time has passed. All waits are counted in system clock cycles, using a clocks-per-microsecond parameter.

Requests that cannot be served are either dropped silently or refused with an error pulse and a cause code. The bench runs with small microsecond-to-cycle values so that every wait fits in a short run.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is held and in the cycle after it, `cnv_n` is 1 and `done`, `err`, `pdown`, `cal_run` and `ready` are 0, and `err_cause` is 00.
- R2: In mode 00 (normal), an accepted request drives `cnv_n` low for exactly PULSE_CYC clock cycles. `cnv_n` goes low in the cycle after the request is sampled.
- R3: In mode 01 (full sleep after each conversion) and mode 11 (partial sleep after each conversion), an accepted request drives `cnv_n` low for exactly WAKE_US*CLK_PER_US cycles.
- R4: After `cnv_n` rises, the first falling edge of `busy` produces a `done` pulse of exactly one cycle. With the default two synchronizer stages, `done` is high in the cycle that begins at the third rising clock edge after `busy` falls. There is exactly one `done` per conversion.
- R5: In mode 10 (sleep regardless), a request is refused. `err` pulses for one cycle, `err_cause` becomes 01, `cnv_n` stays high, and `pdown` is 1 while idle.
- R6: In modes 01 and 11, a request sampled fewer than GAP_US*CLK_PER_US cycles after the previous accepted request is refused: `err` pulses and `err_cause` becomes 10, with no strobe. A request sampled exactly that many cycles later is accepted. Mode 00 has no spacing limit.
- R7: If `busy` does not fall within BUSY_TO_US*CLK_PER_US cycles of `cnv_n` rising, `err` pulses in exactly that cycle with `err_cause` 11, and no `done` follows.
- R8: `pdown` becomes 1 together with `done` in modes 01 and 11, stays 0 after `done` in mode 00, and is 0 whenever `cnv_n` has just fallen.
- R9: If no configuration write has been seen, the first request produces a PULSE_CYC-cycle calibration strobe. `cal_run` is then 1 and `ready` is 0 until exactly CAL_US*CLK_PER_US cycles after `cnv_n` rises, and no `done` is emitted for it.
- R10: A `cfg_wr` pulse seen before any strobe bypasses calibration. `ready` then rises SETTLE_US*CLK_PER_US-1 cycles after reset release. Requests before that point are dropped.
- R11: Requests that arrive while the block is converting, calibrating or still settling produce no strobe and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_mode | input | 2 | Power-management setting: 00 normal, 01 full sleep after conversion, 10 sleep regardless, 11 partial sleep after conversion |
| cfg_wr | input | 1 | One-cycle pulse marking a configuration write to the converter |
| req | input | 1 | One-cycle sample request |
| busy | input | 1 | Converter busy flag, asynchronous |
| cnv_n | output | 1 | Active-low convert-start strobe |
| ready | output | 1 | High when a request would start a conversion |
| done | output | 1 | One-cycle conversion-complete pulse |
| err | output | 1 | One-cycle error pulse |
| err_cause | output | 2 | Cause of the last error: 01 refused mode, 10 spacing, 11 busy timeout |
| pdown | output | 1 | Converter believed to be in power-down |
| cal_run | output | 1 | Power-on calibration strobe or wait in progress |

## Verification
A wrong internal state in this block shows up at the ports through timing. A miscounted low phase appears on the very next `cnv_n` rising edge as a strobe that is too short or too long. A stuck or mis-decoded state shows up as a missing `done`, or as a timeout error exactly BUSY_TO cycles after `cnv_n` rises. A wrong gap counter or start-up flag shows up on the first request that should be refused or accepted: an unexpected strobe or error pulse appears within one cycle of that request. The bench measures each of these intervals in cycles and compares them with values computed from the requirements.

// File: rtl/adc_pwr_seq_pkg.sv
// Shared encodings for the ADC power-mode sequencer.
// Assumes the 2-bit power setting encoding is fixed by the converter.
package adc_pwr_seq_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL        = 2'b00,
        PM_SLEEP_AFTER   = 2'b01,
        PM_SLEEP_ALWAYS  = 2'b10,
        PM_PARTIAL_AFTER = 2'b11
    } pm_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_REFUSED = 2'b01,
        ERR_SPACING = 2'b10,
        ERR_TIMEOUT = 2'b11
    } err_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_LOW      = 3'd1,
        S_CONV     = 3'd2,
        S_CAL_LOW  = 3'd3,
        S_CAL_WAIT = 3'd4
    } seq_st_e;

    // True for modes in which the converter sleeps after each conversion.
    function automatic logic pm_sleeps(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b11);
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
// Synchronizes the converter busy flag and flags its falling edge.
// Assumes busy is asynchronous to clk; adds STAGES cycles of latency
// plus one for the edge register.
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    output logic busy_fall
);
    logic [STAGES:0] shreg;

    // Shift the raw flag through the synchronizer and one edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], busy_in};
        end
    end

    assign busy_fall = shreg[STAGES] & ~shreg[STAGES-1];
endmodule

// File: rtl/adc_sat_timer.sv
// Saturating up-counter that reports when LIMIT-1 has been reached.
// Assumes LIMIT >= 2. START_FULL picks whether reset leaves it expired.
module adc_sat_timer #(
    parameter int LIMIT      = 4,
    parameter bit START_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic reached
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count up from a restart and hold at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= START_FULL ? TOP : '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt == TOP);
endmodule

// File: rtl/adc_seq_core.sv
// Control FSM: decides whether a request is served, times the strobe
// low phase, waits for busy to fall, and runs the power-on calibration.
// Assumes req is a single-cycle pulse and that settled and gap_ok come
// from saturating timers.
module adc_seq_core
    import adc_pwr_seq_pkg::*;
#(
    parameter int PULSE_CYC   = 4,
    parameter int WAKE_CYC    = 500,
    parameter int CAL_CYC     = 7000000,
    parameter int BUSY_TO_CYC = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pm_mode,
    input  logic       cfg_wr,
    input  logic       req,
    input  logic       busy_fall,
    input  logic       settled,
    input  logic       gap_ok,
    output logic       gap_restart,
    output logic       cnv_n,
    output logic       ready,
    output logic       done,
    output logic       err,
    output logic [1:0] err_cause,
    output logic       pdown,
    output logic       cal_run
);
    localparam int M1   = (PULSE_CYC > WAKE_CYC) ? PULSE_CYC : WAKE_CYC;
    localparam int M2   = (CAL_CYC > BUSY_TO_CYC) ? CAL_CYC : BUSY_TO_CYC;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);

    seq_st_e    state;
    logic [CW-1:0] cnt;
    logic       cnv_n_q, done_q, err_q, pdown_q;
    err_e       cause_q;
    logic [1:0] mode_q;
    logic       cal_done, bypass, started;
    logic       need_cal, init_ok, idle_req, refuse_mode, refuse_gap, accept;

    // Decode how a request in the idle state is handled.
    always_comb begin
        need_cal    = !cal_done && !bypass;
        init_ok     = cal_done || (bypass && settled);
        idle_req    = (state == S_IDLE) && req;
        refuse_mode = idle_req && (pm_mode == PM_SLEEP_ALWAYS);
        refuse_gap  = idle_req && !refuse_mode && !need_cal && init_ok
                      && pm_sleeps(pm_mode) && !gap_ok;
        accept      = idle_req && !refuse_mode && !need_cal && init_ok
                      && !refuse_gap;
    end

    // Sequencer state, counters, pulses and power-state tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            cnv_n_q  <= 1'b1;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            cause_q  <= ERR_NONE;
            pdown_q  <= 1'b0;
            mode_q   <= PM_NORMAL;
            cal_done <= 1'b0;
            bypass   <= 1'b0;
            started  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (cfg_wr && !started) begin
                bypass <= 1'b1;
            end
            case (state)
                S_IDLE: begin
                    if (pm_mode == PM_SLEEP_ALWAYS) begin
                        pdown_q <= 1'b1;
                    end
                    if (refuse_mode) begin
                        err_q   <= 1'b1;
                        cause_q <= ERR_REFUSED;
                    end else if (idle_req && need_cal) begin
                        state   <= S_CAL_LOW;
                        cnt     <= CW'(PULSE_CYC - 1);
                        cnv_n_q <= 1'b0;
                        pdown_q <= 1'b0;
                        started <= 1'b1;
                    end else if (refuse_gap) begin
                        err_q   <= 1'b1;
                        cause_q <= ERR_SPACING;
                    end else if (accept) begin
                        state   <= S_LOW;
                        cnt     <= pm_sleeps(pm_mode) ? CW'(WAKE_CYC - 1)
                                                      : CW'(PULSE_CYC - 1);
                        mode_q  <= pm_mode;
                        cnv_n_q <= 1'b0;
                        pdown_q <= 1'b0;
                        started <= 1'b1;
                    end
                end
                S_LOW: begin
                    if (cnt == '0) begin
                        state   <= S_CONV;
                        cnv_n_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_CONV: begin
                    if (busy_fall) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                        if (pm_sleeps(mode_q)) begin
                            pdown_q <= 1'b1;
                        end
                    end else if (cnt == CW'(BUSY_TO_CYC - 1)) begin
                        state   <= S_IDLE;
                        err_q   <= 1'b1;
                        cause_q <= ERR_TIMEOUT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_CAL_LOW: begin
                    if (cnt == '0) begin
                        state   <= S_CAL_WAIT;
                        cnv_n_q <= 1'b1;
                        cnt     <= CW'(CAL_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_CAL_WAIT: begin
                    if (cnt == '0) begin
                        state    <= S_IDLE;
                        cal_done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
            // The conversion wait restarts its count when the strobe rises.
            if (state == S_LOW && cnt == '0) begin
                cnt <= '0;
            end
        end
    end

    assign gap_restart = accept;
    assign cnv_n       = cnv_n_q;
    assign ready       = (state == S_IDLE) && init_ok;
    assign done        = done_q;
    assign err         = err_q;
    assign err_cause   = cause_q;
    assign pdown       = pdown_q;
    assign cal_run     = (state == S_CAL_LOW) || (state == S_CAL_WAIT);
endmodule

// File: rtl/adc_pwr_seq.sv
// Top of the ADC power-mode sequencer. Converts microsecond timing
// parameters to cycle counts and wires the synchronizer, the settle
// and spacing timers and the control FSM.
// Assumes a single clock and synchronous active-low reset.
module adc_pwr_seq #(
    parameter int CLK_PER_US  = 100,
    parameter int PULSE_CYC   = 4,
    parameter int WAKE_US     = 5,
    parameter int SETTLE_US   = 300,
    parameter int CAL_US      = 70000,
    parameter int GAP_US      = 10,
    parameter int BUSY_TO_US  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pm_mode,
    input  logic       cfg_wr,
    input  logic       req,
    input  logic       busy,
    output logic       cnv_n,
    output logic       ready,
    output logic       done,
    output logic       err,
    output logic [1:0] err_cause,
    output logic       pdown,
    output logic       cal_run
);
    localparam int WAKE_CYC    = WAKE_US * CLK_PER_US;
    localparam int SETTLE_CYC  = SETTLE_US * CLK_PER_US;
    localparam int CAL_CYC     = CAL_US * CLK_PER_US;
    localparam int GAP_CYC     = GAP_US * CLK_PER_US;
    localparam int BUSY_TO_CYC = BUSY_TO_US * CLK_PER_US;

    logic busy_fall, settled, gap_ok, gap_restart;

    adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_in   (busy),
        .busy_fall (busy_fall)
    );

    adc_sat_timer #(.LIMIT(SETTLE_CYC), .START_FULL(1'b0)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (1'b0),
        .reached (settled)
    );

    adc_sat_timer #(.LIMIT(GAP_CYC), .START_FULL(1'b1)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (gap_restart),
        .reached (gap_ok)
    );

    adc_seq_core #(
        .PULSE_CYC   (PULSE_CYC),
        .WAKE_CYC    (WAKE_CYC),
        .CAL_CYC     (CAL_CYC),
        .BUSY_TO_CYC (BUSY_TO_CYC)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .pm_mode     (pm_mode),
        .cfg_wr      (cfg_wr),
        .req         (req),
        .busy_fall   (busy_fall),
        .settled     (settled),
        .gap_ok      (gap_ok),
        .gap_restart (gap_restart),
        .cnv_n       (cnv_n),
        .ready       (ready),
        .done        (done),
        .err         (err),
        .err_cause   (err_cause),
        .pdown       (pdown),
        .cal_run     (cal_run)
    );
endmodule

// File: rtl/adc_pwr_seq_chk.sv
// Property checker for the sequencer, attached by bind.
// Assumes the port encodings listed in the brief.
module adc_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pm_mode,
    input logic       cnv_n,
    input logic       ready,
    input logic       done,
    input logic       err,
    input logic [1:0] err_cause,
    input logic       pdown,
    input logic       cal_run
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cnv_n); // R4
    AST_NO_STROBE_MODE10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_n) |-> ($past(pm_mode) != 2'b10)); // R5
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_cause != 2'b00)); // R6
    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !done); // R7
    AST_WAKE_CLEARS_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_n) |-> !pdown); // R8
    AST_CAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_run |-> (!done && !ready)); // R9
    AST_STROBE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_n |-> !ready); // R11
endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pm_mode   (pm_mode),
    .cnv_n     (cnv_n),
    .ready     (ready),
    .done      (done),
    .err       (err),
    .err_cause (err_cause),
    .pdown     (pdown),
    .cal_run   (cal_run)
);

// File: tb/test_adc_pwr_seq.sv
// Bench for the ADC power-mode sequencer: directed start-up, spacing,
// refusal and timeout cases plus seeded random conversions.
module test_adc_pwr_seq;
    localparam int CPU      = 4;
    localparam int PULSE    = 2;
    localparam int WAKE     = 5 * CPU;
    localparam int SETTLE   = 30 * CPU;
    localparam int CAL      = 100 * CPU;
    localparam int GAP      = 10 * CPU;
    localparam int TO       = 8 * CPU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pm_mode = 2'b00;
    logic       cfg_wr = 1'b0;
    logic       req = 1'b0;
    logic       busy = 1'b0;
    logic       cnv_n, ready, done, err, pdown, cal_run;
    logic [1:0] err_cause;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // converter model controls
    int conv_cyc = 4;
    bit no_busy = 1'b1;

    // monitor state
    int nidx = 0, fall_idx = 0, rise_idx = 0, low_len = 0;
    int strb_cnt = 0, done_cnt = 0, err_cnt = 0, done_idx = 0, err_idx = 0;
    int double_done = 0;
    logic [1:0] last_cause = 2'b00;
    logic pd_at_done = 1'b0;
    logic prev_cnv = 1'b1, prev_done = 1'b0;

    always #2.5 clk = ~clk;

    adc_pwr_seq #(
        .CLK_PER_US (CPU),
        .PULSE_CYC  (PULSE),
        .WAKE_US    (5),
        .SETTLE_US  (30),
        .CAL_US     (100),
        .GAP_US     (10),
        .BUSY_TO_US (8),
        .SYNC_STAGES(2)
    ) i_adc_pwr_seq (
        .clk(clk), .rst_n(rst_n), .pm_mode(pm_mode), .cfg_wr(cfg_wr),
        .req(req), .busy(busy), .cnv_n(cnv_n), .ready(ready), .done(done),
        .err(err), .err_cause(err_cause), .pdown(pdown), .cal_run(cal_run)
    );

    function automatic int exp_low(input logic [1:0] m);
        return (m == 2'b01 || m == 2'b11) ? WAKE : PULSE;
    endfunction

    function automatic logic exp_pd(input logic [1:0] m);
        return (m == 2'b01 || m == 2'b11);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Converter model: busy rises after the strobe rises, falls conv_cyc later.
    initial begin
        forever begin
            @(posedge cnv_n);
            if (!no_busy) begin
                @(negedge clk) busy = 1'b1;
                repeat (conv_cyc) @(negedge clk);
                busy = 1'b0;
            end
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        nidx++;
        if (prev_cnv === 1'b1 && cnv_n === 1'b0) begin
            fall_idx = nidx;
            strb_cnt++;
        end
        if (prev_cnv === 1'b0 && cnv_n === 1'b1) begin
            rise_idx = nidx;
            low_len  = nidx - fall_idx;
        end
        if (done === 1'b1) begin
            done_cnt++;
            done_idx   = nidx;
            pd_at_done = pdown;
            if (prev_done === 1'b1) double_done++;
        end
        if (err === 1'b1) begin
            err_cnt++;
            err_idx    = nidx;
            last_cause = err_cause;
        end
        prev_cnv  = (cnv_n === 1'b0) ? 1'b0 : 1'b1;
        prev_done = (done === 1'b1);
    end

    // One request, waits for its outcome and checks it.
    task automatic do_conv(input logic [1:0] m, input int c);
        int s0, d0, e0, waited;
        conv_cyc = c;
        no_busy  = 1'b0;
        @(posedge clk);
        s0 = strb_cnt; d0 = done_cnt; e0 = err_cnt;
        @(negedge clk) pm_mode = m; req = 1'b1;
        @(negedge clk) req = 1'b0;
        waited = 0;
        while (done_cnt == d0 && err_cnt == e0 && waited < 300) begin
            @(posedge clk);
            waited++;
        end
        if (m == 2'b10) begin
            chk(err_cnt == e0 + 1, "R5 refusal err", err_cnt - e0, 1);
            chk(last_cause == 2'b01, "R5 cause", int'(last_cause), 1);
            chk(strb_cnt == s0, "R5 no strobe", strb_cnt - s0, 0);
        end else begin
            chk(done_cnt == d0 + 1, "R4 one done", done_cnt - d0, 1);
            if (m == 2'b00) chk(low_len == PULSE, "R2 low width", low_len, PULSE);
            else            chk(low_len == exp_low(m), "R3 low width", low_len, exp_low(m));
            chk(done_idx - rise_idx == c + 3, "R4 done latency", done_idx - rise_idx, c + 3);
            chk(pd_at_done == exp_pd(m), "R8 pdown at done", int'(pd_at_done), int'(exp_pd(m)));
        end
        repeat (GAP) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s0, d0, e0, waited;
        logic [1:0] m;
        void'($urandom(32'h5EED_0042));

        // ---- R1: reset state ----
        repeat (4) @(negedge clk);
        chk(cnv_n == 1'b1 && done == 1'b0 && err == 1'b0, "R1 reset outputs", int'(cnv_n), 1);
        chk(pdown == 1'b0 && cal_run == 1'b0 && ready == 1'b0 && err_cause == 2'b00,
            "R1 reset status", int'({pdown, cal_run, ready, err_cause}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnv_n == 1'b1 && ready == 1'b0, "R1 after release", int'({cnv_n, ready}), 2);

        // ---- R9: calibration path, request during it ignored (R11) ----
        pm_mode = 2'b00; req = 1'b1;
        @(negedge clk) req = 1'b0;
        chk(cnv_n == 1'b0 && cal_run == 1'b1, "R9 cal strobe low", int'({cnv_n, cal_run}), 1);
        repeat (PULSE) @(negedge clk);
        chk(cnv_n == 1'b1, "R9 cal strobe width", int'(cnv_n), 1);
        req = 1'b1;
        @(negedge clk) req = 1'b0;
        repeat (CAL - 2) @(negedge clk);
        chk(ready == 1'b0 && cal_run == 1'b1, "R9 cal still running", int'({ready, cal_run}), 1);
        @(negedge clk);
        chk(ready == 1'b1 && cal_run == 1'b0, "R9 cal finished", int'({ready, cal_run}), 2);
        chk(done_cnt == 0, "R9 no done for cal", done_cnt, 0);
        chk(strb_cnt == 1, "R11 no strobe during cal", strb_cnt, 1);

        // ---- R2/R3/R4/R8 directed per mode ----
        do_conv(2'b00, 2);
        do_conv(2'b01, 5);
        do_conv(2'b11, 10);

        // ---- R5: mode 10 refused, pdown reported ----
        do_conv(2'b10, 3);
        chk(pdown == 1'b1, "R5 pdown in mode 10", int'(pdown), 1);

        // ---- R6: spacing boundary in mode 01, then no limit in mode 00 ----
        conv_cyc = 3; no_busy = 1'b0;
        @(posedge clk);
        s0 = strb_cnt; e0 = err_cnt; d0 = done_cnt;
        @(negedge clk) pm_mode = 2'b01; req = 1'b1;
        @(negedge clk) req = 1'b0;
        repeat (GAP - 2) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        chk(err == 1'b1 && err_cause == 2'b10, "R6 reject inside gap", int'({err, err_cause}), 6);
        chk(cnv_n == 1'b1, "R6 no strobe on reject", int'(cnv_n), 1);
        @(negedge clk) req = 1'b0;
        chk(cnv_n == 1'b0 && pdown == 1'b0, "R6 accept at gap / R8 wake", int'({cnv_n, pdown}), 0);
        waited = 0;
        while (done_cnt < d0 + 2 && waited < 300) begin @(posedge clk); waited++; end
        chk(strb_cnt == s0 + 2 && err_cnt == e0 + 1, "R6 strobe count", strb_cnt - s0, 2);
        @(negedge clk) pm_mode = 2'b00; req = 1'b1;
        @(negedge clk) req = 1'b0;
        chk(cnv_n == 1'b0, "R6 mode 00 has no gap", int'(cnv_n), 0);
        waited = 0;
        while (done_cnt < d0 + 3 && waited < 300) begin @(posedge clk); waited++; end
        chk(pd_at_done == 1'b0, "R8 mode 00 stays awake", int'(pd_at_done), 0);
        repeat (GAP) @(negedge clk);

        // ---- R11: request while converting is dropped ----
        conv_cyc = 10;
        @(posedge clk);
        s0 = strb_cnt; e0 = err_cnt; d0 = done_cnt;
        @(negedge clk) pm_mode = 2'b00; req = 1'b1;
        @(negedge clk) req = 1'b0;
        repeat (4) @(negedge clk);
        req = 1'b1;
        @(negedge clk) req = 1'b0;
        waited = 0;
        while (done_cnt == d0 && waited < 300) begin @(posedge clk); waited++; end
        chk(strb_cnt == s0 + 1 && err_cnt == e0, "R11 busy request dropped", strb_cnt - s0, 1);
        repeat (GAP) @(negedge clk);

        // ---- R7: busy never toggles ----
        no_busy = 1'b1;
        @(posedge clk);
        e0 = err_cnt; d0 = done_cnt;
        @(negedge clk) pm_mode = 2'b00; req = 1'b1;
        @(negedge clk) req = 1'b0;
        waited = 0;
        while (err_cnt == e0 && waited < 300) begin @(posedge clk); waited++; end
        chk(last_cause == 2'b11, "R7 timeout cause", int'(last_cause), 3);
        chk(err_idx - rise_idx == TO, "R7 timeout cycle", err_idx - rise_idx, TO);
        chk(done_cnt == d0, "R7 no done", done_cnt - d0, 0);
        no_busy = 1'b0;
        repeat (GAP) @(negedge clk);

        // ---- random conversions across all modes ----
        for (int i = 0; i < 24; i++) begin
            m = 2'($urandom % 4);
            do_conv(m, 2 + int'($urandom % 9));
        end

        // ---- R10: bypass path after a fresh reset ----
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; cfg_wr = 1'b1;
        @(negedge clk) cfg_wr = 1'b0; pm_mode = 2'b00; req = 1'b1;
        s0 = strb_cnt;
        @(negedge clk) req = 1'b0;
        repeat (SETTLE - 4) @(negedge clk);
        chk(ready == 1'b0 && strb_cnt == s0, "R10 dropped while settling", strb_cnt - s0, 0);
        @(negedge clk);
        chk(ready == 1'b1 && cal_run == 1'b0, "R10 ready after settle", int'({ready, cal_run}), 2);
        do_conv(2'b01, 4);
        chk(cal_run == 1'b0, "R10 no calibration", int'(cal_run), 0);

        chk(double_done == 0, "R4 done width", double_done, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule